// File: doc/BRIEF.md
# Cross-Domain Programmable Periodic Timer

This block is a periodic timer whose period is programmed from a fast bus clock domain and counted in a separate, slower counting clock domain. A bus write strobe loads a period value into a register in the bus domain. That value then reaches the counting domain as a coherent multibit word. The bus domain watches the counting clock through a two-flop synchronizer. Just after each counting-clock rising edge it raises a capture enable, which copies the period into a holding register. The counting domain reads the holding register at its next edge, when the copy is already settled.

The counter advances only on counting-clock edges where the tick enable input is high. When tick is tied high, the counter runs at the full counting-clock rate. When tick is driven as a rate enable, the same logic works as a clock-enabled counter. The comparison between the next count and the period is registered. Once that match flag is set, the counter clears, and each set flag flips an event toggle. The toggle passes back to the bus domain through a two-flop synchronizer, and a change detector there turns each flip into a one-cycle interrupt pulse.

Top module: `cdc_period_timer`

## Requirements
- R1: While the bus reset is low, `irq_pulse` stays low. After reset, the period register and its holding copy both hold RST_PERIOD (default 0), so interrupts start at a spacing of one tick.
- R2: A bus cycle with `wr_en` high loads `wr_data` as the new period. Once the counting domain has taken up the new value, the interrupt spacing follows it, whatever period was programmed before.
- R3: With period P and tick held high, consecutive interrupt pulses are P+1 counting-clock cycles apart. The counter clears to zero on the tick after the match flag sets, and on every other tick it increments by one.
- R4: A period of zero raises an interrupt on every tick.
- R5: Each interrupt is a pulse exactly one bus-clock cycle wide, and there is one pulse per terminal-count event.
- R6: The full-scale period 2^W-1 gives a spacing of 2^W ticks.
- R7: While `cnt_tick` is low, the counter, the match flag and the event toggle all hold their values, and no new interrupt is raised.
- R8: If `cnt_tick` is high on every second counting-clock cycle, the spacing becomes 2(P+1) counting-clock cycles.
- R9: The holding copy of the period is loaded only by a capture enable. That enable lasts one bus cycle and follows the synchronized rising edge of the counting clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus-domain clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| wr_en | input | 1 | Period write strobe |
| wr_data | input | W | Period value to load |
| cnt_clk | input | 1 | Slow counting-domain clock |
| cnt_rst_n | input | 1 | Synchronous active-low reset, counting domain |
| cnt_tick | input | 1 | Counting enable, sampled on cnt_clk |
| irq_pulse | output | 1 | One-cycle interrupt pulse in the bus domain |

## Verification
The main function is driven with directed periods of zero, one and full scale, which expose errors in the clear rule, in the P+1 spacing and in counter wrap. Random periods are then written in sequence, and each rewrite shows whether the captured copy actually follows the bus register. Two tick patterns are also used: an alternating tick, which separates counting by tick from counting by clock, and a tick held low, which shows whether the counter truly stalls. Pulse width is watched the whole time, so a level-style interrupt or a doubled pulse is caught.

// File: rtl/cdc_timer_pkg.sv
// Shared constants for the cross-domain periodic timer.
// Assumes: every single-bit crossing uses the same synchronizer depth.
package cdc_timer_pkg;
    localparam int unsigned SYNC_DEPTH = 2;

    // Interrupt spacing in counting ticks for a programmed period value.
    function automatic int unsigned ticks_per_event(input int unsigned period);
        return period + 1;
    endfunction
endpackage

// File: rtl/tmr_sync_bit.sv
// Multi-flop single-bit synchronizer.
// Assumes: d is a level that is stable for longer than DEPTH destination
// cycles; the first stage is the only flop that samples d.
module tmr_sync_bit #(
    parameter int unsigned DEPTH = cdc_timer_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] stage_q;

    // Shift the asynchronous level through DEPTH flops.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[DEPTH-2:0], d};
    end

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/tmr_period_xfer.sv
// Bus-side period register and its coherent hand-over to the counting domain.
// The counting clock level is synchronized into the bus domain; one bus
// cycle after its synchronized rising edge the period is copied into a
// holding register, which stays stable until the next counting edge.
// Assumes: the counting clock high and low phases each last longer than
// DEPTH+2 bus cycles.
module tmr_period_xfer #(
    parameter int unsigned W          = 8,
    parameter logic [W-1:0] RST_PERIOD = '0
) (
    input  logic         bus_clk,
    input  logic         bus_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         cnt_clk_lvl,
    output logic [W-1:0] period_hold
);
    logic [W-1:0] period_q;
    logic         clk_seen;
    logic         clk_seen_d;
    logic         cap_en;

    // Period register: loads bus data on every strobe.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n)  period_q <= RST_PERIOD;
        else if (wr_en)  period_q <= wr_data;
    end

    tmr_sync_bit u_clk_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     (cnt_clk_lvl),
        .q     (clk_seen)
    );

    // Delay of the synchronized counting clock for edge detection.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) clk_seen_d <= 1'b0;
        else            clk_seen_d <= clk_seen;
    end

    assign cap_en = clk_seen & ~clk_seen_d;

    // Holding copy: refreshed just after each counting-clock edge.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n)  period_hold <= RST_PERIOD;
        else if (cap_en) period_hold <= period_q;
    end

    // R9: the capture enable is a single-cycle strobe.
    p_capture_single_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        cap_en |=> !cap_en);

    // R9: the holding copy moves only in the cycle after a capture enable.
    p_hold_quiet_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (!cap_en && !$past(cap_en)) |=> $stable(period_hold) || $past(cap_en));
endmodule

// File: rtl/tmr_count_core.sv
// Counting-domain core: tick-enabled counter, registered terminal compare
// and event toggle.
// Assumes: period is stable around every cnt_clk rising edge (guaranteed by
// the capture scheme in the bus domain).
module tmr_count_core #(
    parameter int unsigned W = 8
) (
    input  logic         cnt_clk,
    input  logic         cnt_rst_n,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic         evt_tgl
);
    logic [W-1:0] count_q;
    logic [W-1:0] count_nx;
    logic         match_q;

    // Next count: clear after a registered match, otherwise step by one.
    always_comb begin
        count_nx = match_q ? '0 : count_q + 1'b1;
    end

    // Counter, registered compare and event toggle, all gated by tick.
    always_ff @(posedge cnt_clk) begin
        if (!cnt_rst_n) begin
            count_q <= '1;
            match_q <= 1'b0;
            evt_tgl <= 1'b0;
        end else if (tick) begin
            count_q <= count_nx;
            match_q <= (count_nx == period);
            evt_tgl <= evt_tgl ^ match_q;
        end
    end

    // R3: a set match flag clears the counter on the next tick.
    p_clear_after_match_r3: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
        (tick && match_q) |=> (count_q == '0));

    // R3: without a match the counter steps by exactly one.
    p_step_one_r3: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
        (tick && !match_q) |=> (count_q == $past(count_q) + 1'b1));

    // R4: every match tick produces an event toggle.
    p_event_on_match_r4: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
        (tick && match_q) |=> (evt_tgl != $past(evt_tgl)));

    // R7: no tick, no state change.
    p_stall_no_tick_r7: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
        !tick |=> ($stable(count_q) && $stable(match_q) && $stable(evt_tgl)));
endmodule

// File: rtl/tmr_irq_out.sv
// Bus-domain interrupt generator: synchronizes the event toggle and emits
// a one-cycle pulse on each change.
// Assumes: toggles are spaced by more than DEPTH+2 bus cycles.
module tmr_irq_out (
    input  logic bus_clk,
    input  logic bus_rst_n,
    input  logic evt_tgl,
    output logic irq_pulse
);
    logic tgl_s;
    logic tgl_d;

    tmr_sync_bit u_evt_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     (evt_tgl),
        .q     (tgl_s)
    );

    // Change detector and registered pulse.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            tgl_d     <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            tgl_d     <= tgl_s;
            irq_pulse <= tgl_s ^ tgl_d;
        end
    end

    // R5: an interrupt never lasts two bus cycles.
    p_single_pulse_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        irq_pulse |=> !irq_pulse);

    // R5: a pulse follows a change of the synchronized toggle.
    p_pulse_has_cause_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(irq_pulse) |-> ($past(tgl_s) != $past(tgl_d)));
endmodule

// File: rtl/cdc_period_timer.sv
// Cross-domain programmable periodic timer (top level).
// Bus domain holds the period register and produces the interrupt pulse;
// counting domain runs the tick-enabled counter and compare.
// Assumes: cnt_clk is at least (2*DEPTH+4) times slower than bus_clk.
module cdc_period_timer #(
    parameter int unsigned  W          = 8,
    parameter logic [W-1:0] RST_PERIOD = '0
) (
    input  logic         bus_clk,
    input  logic         bus_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         cnt_clk,
    input  logic         cnt_rst_n,
    input  logic         cnt_tick,
    output logic         irq_pulse
);
    logic [W-1:0] period_hold;
    logic         evt_tgl;

    tmr_period_xfer #(.W(W), .RST_PERIOD(RST_PERIOD)) u_xfer (
        .bus_clk     (bus_clk),
        .bus_rst_n   (bus_rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cnt_clk_lvl (cnt_clk),
        .period_hold (period_hold)
    );

    tmr_count_core #(.W(W)) u_core (
        .cnt_clk   (cnt_clk),
        .cnt_rst_n (cnt_rst_n),
        .tick      (cnt_tick),
        .period    (period_hold),
        .evt_tgl   (evt_tgl)
    );

    tmr_irq_out u_irq (
        .bus_clk   (bus_clk),
        .bus_rst_n (bus_rst_n),
        .evt_tgl   (evt_tgl),
        .irq_pulse (irq_pulse)
    );

    // R1: quiet output right after reset.
    p_reset_quiet_r1: assert property (@(posedge bus_clk)
        !bus_rst_n |=> !irq_pulse);
endmodule

// File: tb/cdc_period_timer_tb.sv
`timescale 1ns/1ps
module cdc_period_timer_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int SLOW_PERIOD = 86;
    localparam int W           = 8;
    localparam int WATCHDOG    = 190000;

    logic         bus_clk = 1'b0;
    logic         cnt_clk = 1'b0;
    logic         bus_rst_n = 1'b0;
    logic         cnt_rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         cnt_tick = 1'b1;
    logic         irq_pulse;

    int     checks = 0;
    int     errors = 0;
    int     pulse_cnt = 0;
    int     wide_pulses = 0;
    longint t_last = 0;
    bit     prev_irq = 1'b0;
    int     tick_mode = 0;   // 0 always, 1 alternate, 2 held low
    bit     done = 1'b0;
    int     cycles = 0;

    always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
    always #(SLOW_PERIOD/2) cnt_clk = ~cnt_clk;

    cdc_period_timer #(.W(W)) dut_i (
        .bus_clk   (bus_clk),
        .bus_rst_n (bus_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cnt_clk   (cnt_clk),
        .cnt_rst_n (cnt_rst_n),
        .cnt_tick  (cnt_tick),
        .irq_pulse (irq_pulse)
    );

    // Tick pattern driven away from the counting edge.
    always @(negedge cnt_clk) begin
        case (tick_mode)
            1:       cnt_tick <= ~cnt_tick;
            2:       cnt_tick <= 1'b0;
            default: cnt_tick <= 1'b1;
        endcase
    end

    // Pulse monitor sampled between bus edges.
    always @(negedge bus_clk) begin
        cycles <= cycles + 1;
        if (irq_pulse) begin
            pulse_cnt = pulse_cnt + 1;
            t_last    = $time;
            if (prev_irq) wide_pulses = wide_pulses + 1;
        end
        prev_irq = irq_pulse;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge bus_clk) begin
        if (!done && cycles > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired actual %0d expected below %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic longint exp_gap(input int p, input int div);
        return longint'(p + 1) * div * SLOW_PERIOD;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_period(input int p);
        @(negedge bus_clk);
        wr_en   = 1'b1;
        wr_data = W'(p);
        @(negedge bus_clk);
        wr_en   = 1'b0;
    endtask

    // Let two pulses pass to flush the old period, then time two gaps.
    task automatic measure(input int p, input int div, input string req);
        int     base;
        longint t0;
        longint t1;
        longint e;
        base = pulse_cnt;
        wait (pulse_cnt >= base + 2);
        t0 = t_last;
        for (int k = 3; k <= 4; k++) begin
            wait (pulse_cnt >= base + k);
            t1 = t_last;
            e  = exp_gap(p, div);
            check((t1 - t0 >= e - CLK_PERIOD) && (t1 - t0 <= e + CLK_PERIOD), req, t1 - t0, e);
            t0 = t1;
        end
    endtask

    initial begin
        int seed_val;
        int p;
        int base;
        seed_val = $urandom(32'd7331);

        // R1: output quiet through reset.
        for (int i = 0; i < 30; i++) begin
            @(negedge bus_clk);
            check(irq_pulse == 1'b0, "R1 reset quiet", longint'(irq_pulse), 0);
        end
        @(negedge cnt_clk);
        cnt_rst_n = 1'b1;
        @(negedge bus_clk);
        bus_rst_n = 1'b1;

        // R1/R4: default period zero fires every tick.
        measure(0, 1, "R1 R4 default spacing");

        // R3: period one.
        write_period(1);
        measure(1, 1, "R3 period one");

        // R6: full scale period.
        write_period((1 << W) - 1);
        measure((1 << W) - 1, 1, "R6 full scale");

        // R4: rewrite back to zero.
        write_period(0);
        measure(0, 1, "R4 zero after rewrite");

        // R2/R3: random rewrites.
        for (int i = 0; i < 8; i++) begin
            p = $urandom_range(40, 0);
            write_period(p);
            measure(p, 1, "R2 R3 random period");
        end

        // R8: alternate tick doubles the spacing.
        write_period(5);
        measure(5, 1, "R3 before gating");
        @(negedge cnt_clk);
        tick_mode = 1;
        measure(5, 2, "R8 gated tick");

        // R7: tick held low stops interrupts.
        @(negedge cnt_clk);
        tick_mode = 2;
        repeat (4) @(negedge cnt_clk);
        base = pulse_cnt;
        repeat (40) @(negedge cnt_clk);
        check(pulse_cnt == base, "R7 stalled no irq", longint'(pulse_cnt - base), 0);
        @(negedge cnt_clk);
        tick_mode = 0;
        measure(5, 1, "R7 resume spacing");

        // R5: pulses were always one bus cycle wide.
        check(wide_pulses == 0, "R5 single cycle pulse", longint'(wide_pulses), 0);
        check(pulse_cnt > 40, "R5 pulses seen", longint'(pulse_cnt), 41);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule